// File: doc/BRIEF.md
# Four-Line Oversampling Serial Receiver

This block receives four asynchronous serial lines at the same time. Each line carries 8N1 frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A line rests high when idle. The nominal rate is 31250 bit/s. The four lines have no phase relation to one another. One divider turns the system clock into a single sample strobe at three times the bit rate, and all four channels use it. Each line passes through its own two-flop synchroniser before it is sampled.

On each strobe, a channel looks at its latest sample. A start is accepted only when a high sample is followed by two low samples in a row. One low sample on its own is treated as noise and dropped. The data sampling phase is set at the strobe that confirms the start, and it advances by three strobes per bit from there. Every channel keeps its own phase. As a result, every data sample and the stop sample fall in the middle third of their bit.

When the stop sample is taken, the channel shows the assembled byte and pulses a valid strobe for one clock. A framing-error flag goes with that pulse when the stop sample was low. After a framing error, the channel ignores the line until it sees a high sample again. Buffering, routing and transmit belong to the logic around this block.

Top module: `uart4_rx_top`

## Requirements
- R1: The sample strobe period is CLK_HZ/(3*BAUD_HZ) clocks, rounded to nearest. At the nominal rate, the valid pulse for a frame appears between 9 bit times plus one third of a bit and 9 bit times plus two thirds of a bit after the falling start edge, plus at most 4 clocks of synchroniser and output latency.
- R2: After reset, the valid, framing-error and data outputs of every channel are all zero.
- R3: A frame on a line delivers its eight data bits on that channel's data lane, with the first data bit after the start in bit 0. The valid strobe is high for exactly one clock. The data lane keeps the byte until the next valid strobe.
- R4: A low pulse shorter than one sample strobe period on an idle line delivers no byte. A frame that follows it is still received correctly.
- R5: A channel accepts a start only after it has seen a high sample. A line held low from reset, for longer than a frame, delivers nothing until it goes high.
- R6: A frame whose stop sample is low delivers its byte with the framing-error flag high during the valid strobe. While the line then stays low, no further byte is delivered. The next frame after the line returns high is received with the flag low.
- R7: The channels are independent. Frames started at unrelated times on all four lines, overlapping in time, are each received correctly on their own lane.
- R8: Frames sent 2% faster or 2% slower than nominal, back to back, are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | NCH | Serial lines, one bit per channel, idle high |
| rx_data_o | output | NCH*DATA_BITS | Received bytes; channel c uses bits [c*DATA_BITS +: DATA_BITS] |
| rx_valid_o | output | NCH | One-clock strobe per channel when a byte is delivered |
| rx_ferr_o | output | NCH | Framing-error flag per channel, valid while the strobe is high |

## Verification
The assertions assume that the sample strobe is at least two clocks apart. They also assume that any line level they react to has already passed through the synchroniser, so only synchronised samples taken on a strobe can move a channel's state. The bench keeps glitches shorter than one strobe period and keeps rate errors within 2%, so a real start always yields at least two low samples. It also drives the lines from timed delays that are not tied to the clock, so edges land at varied phases against the shared strobe.

// File: rtl/uart4_rx_pkg.sv
`timescale 1ns/1ps
package uart4_rx_pkg;

    // samples per bit; start confirmation relies on this being three
    localparam int unsigned OSR = 3;

    typedef enum logic [2:0] {
        CH_WAIT_HIGH = 3'd0,   // need one high sample before hunting
        CH_HUNT      = 3'd1,   // idle, looking for a low sample
        CH_CONFIRM   = 3'd2,   // one low sample seen, need a second
        CH_DATA      = 3'd3,   // collecting data bits
        CH_STOP      = 3'd4    // waiting for the stop sample
    } ch_state_e;

endpackage

// File: rtl/uart4_rx_tick.sv
`timescale 1ns/1ps
module uart4_rx_tick #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned BAUD_HZ = 31_250,
    parameter int unsigned OSR     = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned SAMPLE_HZ = BAUD_HZ * OSR;
    localparam int unsigned DIV_RAW   = (CLK_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ;
    localparam int unsigned DIV       = (DIV_RAW < 2) ? 2 : DIV_RAW;
    localparam int unsigned CW        = $clog2(DIV);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R1: strobes are isolated single-clock pulses
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);

    // R1: a strobe is followed by a counter restart from zero
    p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> (st_q.cnt == '0));

endmodule

// File: rtl/uart4_rx_sync.sv
`timescale 1ns/1ps
module uart4_rx_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    // reset to the idle-high line level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/uart4_rx_chan.sv
`timescale 1ns/1ps
module uart4_rx_chan
    import uart4_rx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 line_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);
    localparam int unsigned PW = $clog2(OSR);
    localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [PW-1:0] PH_RELOAD = PW'(OSR - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    typedef struct packed {
        ch_state_e            state;
        logic [PW-1:0]        phase;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 ferr;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ferr  = 1'b0;
        if (tick_i) begin
            unique case (st_q.state)
                CH_WAIT_HIGH: begin
                    if (line_i) st_d.state = CH_HUNT;
                end
                CH_HUNT: begin
                    if (!line_i) st_d.state = CH_CONFIRM;
                end
                CH_CONFIRM: begin
                    if (!line_i) begin
                        // second low sample: start accepted, phase anchored here
                        st_d.state = CH_DATA;
                        st_d.phase = PH_RELOAD;
                        st_d.idx   = '0;
                    end else begin
                        // isolated low sample: drop it
                        st_d.state = CH_HUNT;
                    end
                end
                CH_DATA: begin
                    if (st_q.phase == '0) begin
                        st_d.phase = PH_RELOAD;
                        st_d.shreg = {line_i, st_q.shreg[DATA_BITS-1:1]};
                        if (st_q.idx == IDX_LAST) st_d.state = CH_STOP;
                        else                      st_d.idx   = st_q.idx + 1'b1;
                    end else begin
                        st_d.phase = st_q.phase - 1'b1;
                    end
                end
                CH_STOP: begin
                    if (st_q.phase == '0) begin
                        st_d.valid = 1'b1;
                        st_d.data  = st_q.shreg;
                        st_d.ferr  = !line_i;
                        st_d.state = line_i ? CH_HUNT : CH_WAIT_HIGH;
                    end else begin
                        st_d.phase = st_q.phase - 1'b1;
                    end
                end
                default: st_d.state = CH_WAIT_HIGH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= CH_WAIT_HIGH;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign ferr_o  = st_q.ferr;

    // R3: the delivery strobe lasts a single clock
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R3: the delivered byte holds between strobes
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> $stable(st_q.data));

    // R6: the error flag only ever qualifies a delivery
    p_ferr_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ferr |-> st_q.valid);

    // R6: after a low stop sample the channel waits for a high line
    p_ferr_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ferr |-> (st_q.state == CH_WAIT_HIGH));

    // R4: a high sample after a single low sample returns to hunting
    p_glitch_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_CONFIRM && tick_i && line_i) |=> (st_q.state == CH_HUNT));

    // R5: no low sample can leave the wait-for-high state
    p_need_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_WAIT_HIGH && tick_i && !line_i) |=> (st_q.state == CH_WAIT_HIGH));

    // R7: a channel moves only on the shared strobe
    p_state_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.state));

endmodule

// File: rtl/uart4_rx_top.sv
`timescale 1ns/1ps
module uart4_rx_top
    import uart4_rx_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BAUD_HZ   = 31_250
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           rx_line_i,
    output logic [NCH*DATA_BITS-1:0] rx_data_o,
    output logic [NCH-1:0]           rx_valid_o,
    output logic [NCH-1:0]           rx_ferr_o
);
    logic           tick;
    logic [NCH-1:0] line_s;

    uart4_rx_tick #(
        .CLK_HZ  (CLK_HZ),
        .BAUD_HZ (BAUD_HZ),
        .OSR     (OSR)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    uart4_rx_sync #(
        .W (NCH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rx_line_i),
        .sync_o  (line_s)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        uart4_rx_chan #(
            .DATA_BITS (DATA_BITS)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .line_i  (line_s[g]),
            .data_o  (rx_data_o[g*DATA_BITS +: DATA_BITS]),
            .valid_o (rx_valid_o[g]),
            .ferr_o  (rx_ferr_o[g])
        );
    end

    // R7: deliveries happen only in the clock after a shared strobe
    p_valid_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid_o) |-> $past(tick));

endmodule

// File: tb/uart4_rx_top_tb_top.sv
`timescale 1ns/1ps
module uart4_rx_top_tb_top;
    localparam int unsigned NCH     = 4;
    localparam int unsigned CLK_HZ  = 125_000_000;
    localparam int unsigned BAUD_HZ = 2_083_333;   // strobe every 20 clocks
    localparam real         BIT_NS  = 480.0;       // 60 clocks per bit
    localparam int          MAXCAP  = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       line = '1;
    logic [NCH*8-1:0]     rx_data;
    logic [NCH-1:0]       rx_valid;
    logic [NCH-1:0]       rx_ferr;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    int  cyc      = 0;
    int  start_cyc [NCH];

    logic [7:0] cap_d   [NCH][MAXCAP];
    logic       cap_e   [NCH][MAXCAP];
    int         cap_cyc [NCH][MAXCAP];
    int         cap_n   [NCH];

    always #4 clk = ~clk;

    uart4_rx_top #(
        .NCH       (NCH),
        .DATA_BITS (8),
        .CLK_HZ    (CLK_HZ),
        .BAUD_HZ   (BAUD_HZ)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line_i  (line),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .rx_ferr_o  (rx_ferr)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial for (int c = 0; c < NCH; c++) cap_n[c] = 0;

    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst_n && rx_valid[c] && cap_n[c] < MAXCAP) begin
                cap_d[c][cap_n[c]]   = rx_data[c*8 +: 8];
                cap_e[c][cap_n[c]]   = rx_ferr[c];
                cap_cyc[c][cap_n[c]] = cyc;
                cap_n[c]             = cap_n[c] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int ch, input logic [7:0] b,
                              input logic stop_lvl, input real bit_ns);
        line[ch] = 1'b0;
        start_cyc[ch] = cyc;
        #(bit_ns);
        for (int i = 0; i < 8; i++) begin
            line[ch] = b[i];
            #(bit_ns);
        end
        line[ch] = stop_lvl;
        #(bit_ns);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 60) @(posedge clk);
    endtask

    task automatic expect_byte(input int ch, input int idx, input logic [7:0] b,
                               input logic e, input string req);
        check(cap_n[ch] > idx, req, cap_n[ch], idx + 1);
        if (cap_n[ch] > idx) begin
            check(cap_d[ch][idx] == b, req, cap_d[ch][idx], b);
            check(cap_e[ch][idx] == e, req, cap_e[ch][idx], e);
        end
    endtask

    // R5 and R2: line 0 is low through reset and long after it
    task automatic t_reset_and_low_line();
        line = 4'b1110;
        rst_n = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(rx_valid == '0, "R2 valid", rx_valid, 0);
        check(rx_ferr == '0, "R2 ferr", rx_ferr, 0);
        check(rx_data == '0, "R2 data", rx_data, 0);
        rst_n = 1'b1;
        wait_bits(20);
        check(cap_n[0] == 0, "R5 no byte from stuck-low line", cap_n[0], 0);
        line[0] = 1'b1;
        wait_bits(2);
        send_frame(0, 8'hC3, 1'b1, BIT_NS);
        wait_bits(2);
        expect_byte(0, 0, 8'hC3, 1'b0, "R5 byte after line goes high");
    endtask

    // R3 and R1: single byte, bit order and strobe timing
    task automatic t_single();
        int base = cap_n[1];
        int dt;
        send_frame(1, 8'hA5, 1'b1, BIT_NS);
        wait_bits(2);
        expect_byte(1, base, 8'hA5, 1'b0, "R3 single byte");
        check(cap_n[1] == base + 1, "R3 exactly one strobe", cap_n[1], base + 1);
        dt = cap_cyc[1][base] - start_cyc[1];
        check(dt >= 558 && dt <= 590, "R1 strobe timing", dt, 574);
        @(negedge clk);
        check(rx_data[15:8] == 8'hA5, "R3 data held", rx_data[15:8], 8'hA5);
    endtask

    // R3: several patterns back to back
    task automatic t_patterns();
        int base = cap_n[1];
        logic [7:0] pat [5] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h6B};
        for (int k = 0; k < 5; k++) send_frame(1, pat[k], 1'b1, BIT_NS);
        wait_bits(2);
        for (int k = 0; k < 5; k++) expect_byte(1, base + k, pat[k], 1'b0, "R3 pattern");
    endtask

    // R7: overlapping frames on all lines at unrelated offsets
    task automatic t_parallel();
        int b0 = cap_n[0];
        int b1 = cap_n[1];
        int b2 = cap_n[2];
        int b3 = cap_n[3];
        fork
            begin send_frame(0, 8'h11, 1'b1, BIT_NS); send_frame(0, 8'hE7, 1'b1, BIT_NS); end
            begin #133; send_frame(1, 8'h2C, 1'b1, BIT_NS); end
            begin #291; send_frame(2, 8'h4D, 1'b1, BIT_NS); send_frame(2, 8'hB2, 1'b1, BIT_NS); end
            begin #417; send_frame(3, 8'h9E, 1'b1, BIT_NS); end
        join
        wait_bits(2);
        expect_byte(0, b0,     8'h11, 1'b0, "R7 ch0 first");
        expect_byte(0, b0 + 1, 8'hE7, 1'b0, "R7 ch0 second");
        expect_byte(1, b1,     8'h2C, 1'b0, "R7 ch1");
        expect_byte(2, b2,     8'h4D, 1'b0, "R7 ch2 first");
        expect_byte(2, b2 + 1, 8'hB2, 1'b0, "R7 ch2 second");
        expect_byte(3, b3,     8'h9E, 1'b0, "R7 ch3");
    endtask

    // R8: rate error of two percent either way
    task automatic t_rate_error();
        int b0 = cap_n[0];
        int b1 = cap_n[1];
        int b2 = cap_n[2];
        int b3 = cap_n[3];
        fork
            begin send_frame(0, 8'h55, 1'b1, BIT_NS * 1.02); send_frame(0, 8'hAA, 1'b1, BIT_NS * 1.02); end
            begin #57;  send_frame(1, 8'h0F, 1'b1, BIT_NS * 0.98); send_frame(1, 8'hF0, 1'b1, BIT_NS * 0.98); end
            begin #201; send_frame(2, 8'h81, 1'b1, BIT_NS * 1.02); end
            begin #350; send_frame(3, 8'h7E, 1'b1, BIT_NS * 0.98); end
        join
        wait_bits(2);
        expect_byte(0, b0,     8'h55, 1'b0, "R8 slow ch0");
        expect_byte(0, b0 + 1, 8'hAA, 1'b0, "R8 slow ch0 second");
        expect_byte(1, b1,     8'h0F, 1'b0, "R8 fast ch1");
        expect_byte(1, b1 + 1, 8'hF0, 1'b0, "R8 fast ch1 second");
        expect_byte(2, b2,     8'h81, 1'b0, "R8 slow ch2");
        expect_byte(3, b3,     8'h7E, 1'b0, "R8 fast ch3");
    endtask

    // R4: a pulse narrower than one strobe period is dropped
    task automatic t_glitch();
        int base = cap_n[2];
        for (int k = 0; k < 3; k++) begin
            line[2] = 1'b0;
            #(100.0 + 3.0 * k);
            line[2] = 1'b1;
            wait_bits(4);
        end
        wait_bits(12);
        check(cap_n[2] == base, "R4 glitch gives no byte", cap_n[2], base);
        send_frame(2, 8'h96, 1'b1, BIT_NS);
        wait_bits(2);
        expect_byte(2, base, 8'h96, 1'b0, "R4 frame after glitch");
    endtask

    // R6: low stop sample, then line held low, then a clean frame
    task automatic t_framing();
        int base = cap_n[3];
        send_frame(3, 8'h3C, 1'b0, BIT_NS);
        wait_bits(14);
        check(cap_n[3] == base + 1, "R6 one byte while held low", cap_n[3], base + 1);
        expect_byte(3, base, 8'h3C, 1'b1, "R6 framing flag");
        line[3] = 1'b1;
        wait_bits(2);
        send_frame(3, 8'h5A, 1'b1, BIT_NS);
        wait_bits(2);
        expect_byte(3, base + 1, 8'h5A, 1'b0, "R6 recovery");
    endtask

    initial begin
        t_reset_and_low_line();
        t_single();
        t_patterns();
        t_parallel();
        t_rate_error();
        t_glitch();
        t_framing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule